// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a write-through cache and a slower lower-level memory. It takes word stores from the processor side in one cycle, holds them in a small circular queue, and sends them to memory one at a time over a request/acknowledge port. The oldest store is always the one presented to memory. The processor therefore keeps running while memory catches up. It stalls only when every slot is occupied and no drain completes in that cycle.

Every slot is looked up by address in parallel on each cycle. A read probe that matches one or more buffered stores returns the data of the most recent of them. A load that misses the cache after a store to the same address therefore gets the buffered value and not stale memory contents. The block reports only hit/no-hit and the forwarded word. The cache arrays and memory reads belong to other logic. The `wb_empty` output lets that logic wait until every store has reached memory.

Top module: `wrbuf_fwd`

## Requirements
- R1: During and right after reset, `wb_empty` is 1, `mem_req` is 0, `wr_ready` is 1 and `rd_hit` is 0.
- R2: While fewer than DEPTH entries are held, `wr_ready` is 1, and a store with `wr_valid` high is captured at that clock edge.
- R3: `mem_req` is 1 whenever at least one entry is held. `mem_addr`/`mem_data` then show the oldest held entry, so stores reach memory in the order they were accepted.
- R4: While `mem_req` is 1 and `mem_ack` is 0, `mem_addr` and `mem_data` keep their values into the next cycle. An entry is released only at a clock edge where `mem_req` and `mem_ack` are both 1.
- R5: With DEPTH entries held, `wr_ready` equals `mem_ack`. A store offered while full is refused when `mem_ack` is 0, and accepted in the same cycle when `mem_ack` is 1.
- R6: With `rd_en` high, `rd_hit` is 1 and `rd_data` equals the buffered data when `rd_addr` equals the address of any held entry. This includes an entry being acknowledged in the current cycle. A store becomes visible to probes in the cycle after it is accepted.
- R7: When several held entries match `rd_addr`, `rd_data` is the data of the most recently accepted one.
- R8: `rd_hit` is 0 and `rd_data` is 0 when `rd_en` is 0 or when no held entry matches.
- R9: `wb_empty` is 1 exactly when no entry is held. It becomes 1 only after a drain acknowledge.
- R10: A store and a drain in the same cycle leave the number of held entries unchanged. Order and contents stay correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store offered |
| wr_addr | input | AW | Store word address |
| wr_data | input | DW | Store data |
| wr_ready | output | 1 | Store can be taken this cycle |
| rd_en | input | 1 | Read probe enable |
| rd_addr | input | AW | Read probe address |
| rd_hit | output | 1 | Probe matched a held store |
| rd_data | output | DW | Data of youngest matching store, else 0 |
| mem_req | output | 1 | Drain request to memory |
| mem_addr | output | AW | Address of oldest held store |
| mem_data | output | DW | Data of oldest held store |
| mem_ack | input | 1 | Memory takes the presented store |
| wb_empty | output | 1 | No store held |

## Verification
The hardest state to reach is a full buffer that holds several stores to the same address. The head slot must be under acknowledge while a new store is accepted and a probe hits both old and young copies. Random stimulus draws addresses from only eight values and gives `mem_ack` a low probability in long stretches, so the queue fills and aliases often. Directed sequences then fill the queue with acknowledge held low, probe it, and push a store with acknowledge high while full.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;
    parameter int unsigned WB_DEPTH_DEF = 4;
    parameter int unsigned WB_AW_DEF    = 16;
    parameter int unsigned WB_DW_DEF    = 32;
endpackage

// File: rtl/wrbuf_ctrl.sv
module wrbuf_ctrl #(
    parameter int unsigned DEPTH = wrbuf_pkg::WB_DEPTH_DEF,
    parameter int unsigned AW    = wrbuf_pkg::WB_AW_DEF,
    parameter int unsigned DW    = wrbuf_pkg::WB_DW_DEF,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_valid_i,
    input  logic [AW-1:0]               wr_addr_i,
    input  logic [DW-1:0]               wr_data_i,
    output logic                        wr_ready_o,
    output logic                        mem_req_o,
    output logic [AW-1:0]               mem_addr_o,
    output logic [DW-1:0]               mem_data_o,
    input  logic                        mem_ack_i,
    output logic                        empty_o,
    output logic [DEPTH-1:0][AW-1:0]    slot_addr_o,
    output logic [DEPTH-1:0][DW-1:0]    slot_data_o,
    output logic [PW-1:0]               head_o,
    output logic [CW-1:0]               count_o
);
    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [CW-1:0]            count;
    } state_t;

    state_t st_q, st_d;
    logic   full, push, pop;

    always_comb begin
        st_d = st_q;
        full = (st_q.count == CW'(DEPTH));
        pop  = (st_q.count != '0) && mem_ack_i;
        push = wr_valid_i && (!full || pop);
        if (push) begin
            st_d.addr[st_q.tail] = wr_addr_i;
            st_d.data[st_q.tail] = wr_data_i;
            st_d.tail            = st_q.tail + PW'(1);
        end
        if (pop) begin
            st_d.head = st_q.head + PW'(1);
        end
        st_d.count = st_q.count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ready_o  = !full || mem_ack_i;
    assign mem_req_o   = (st_q.count != '0);
    assign mem_addr_o  = st_q.addr[st_q.head];
    assign mem_data_o  = st_q.data[st_q.head];
    assign empty_o     = (st_q.count == '0);
    assign slot_addr_o = st_q.addr;
    assign slot_data_o = st_q.data;
    assign head_o      = st_q.head;
    assign count_o     = st_q.count;

    // R4
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (st_q.count < CW'(DEPTH)));

    // R9
    empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_o) |-> $past(mem_req_o && mem_ack_i));
endmodule

// File: rtl/wrbuf_lookup.sv
module wrbuf_lookup #(
    parameter int unsigned DEPTH = wrbuf_pkg::WB_DEPTH_DEF,
    parameter int unsigned AW    = wrbuf_pkg::WB_AW_DEF,
    parameter int unsigned DW    = wrbuf_pkg::WB_DW_DEF,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic                     rd_en_i,
    input  logic [AW-1:0]            rd_addr_i,
    input  logic [DEPTH-1:0][AW-1:0] slot_addr_i,
    input  logic [DEPTH-1:0][DW-1:0] slot_data_i,
    input  logic [PW-1:0]            head_i,
    input  logic [CW-1:0]            count_i,
    output logic                     hit_o,
    output logic [DW-1:0]            data_o
);
    logic [DEPTH-1:0] match;
    logic [PW-1:0]    slot;

    // scan from oldest to youngest; a later match overrides an earlier one
    always_comb begin
        match  = '0;
        hit_o  = 1'b0;
        data_o = '0;
        slot   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = head_i + PW'(k);
            if ((CW'(k) < count_i) && (slot_addr_i[slot] == rd_addr_i)) begin
                match[slot] = 1'b1;
                if (rd_en_i) begin
                    hit_o  = 1'b1;
                    data_o = slot_data_i[slot];
                end
            end
        end
    end
endmodule

// File: rtl/wrbuf_fwd.sv
module wrbuf_fwd #(
    parameter int unsigned DEPTH = wrbuf_pkg::WB_DEPTH_DEF,
    parameter int unsigned AW    = wrbuf_pkg::WB_AW_DEF,
    parameter int unsigned DW    = wrbuf_pkg::WB_DW_DEF,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_hit,
    output logic [DW-1:0] rd_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_ack,
    output logic          wb_empty
);
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0][DW-1:0] slot_data;
    logic [PW-1:0]            head;
    logic [CW-1:0]            count;

    wrbuf_ctrl #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ack_i(mem_ack),
        .empty_o(wb_empty), .slot_addr_o(slot_addr), .slot_data_o(slot_data),
        .head_o(head), .count_o(count)
    );

    wrbuf_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lookup (
        .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .slot_addr_i(slot_addr), .slot_data_i(slot_data),
        .head_i(head), .count_i(count),
        .hit_o(rd_hit), .data_o(rd_data)
    );

    // R6
    hit_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (!wb_empty && rd_en));
endmodule

// File: tb/tb_wrbuf_fwd.sv
module tb_wrbuf_fwd;
    localparam int D = 4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, rd_en = 1'b0, mem_ack = 1'b0;
    logic [15:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_ready, rd_hit, mem_req, wb_empty;
    logic [31:0] rd_data, mem_data;
    logic [15:0] mem_addr;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 1'b0;
    logic [15:0] qa[$];
    logic [31:0] qd[$];

    always #10 clk = ~clk;

    wrbuf_fwd #(.DEPTH(D), .AW(16), .DW(32)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_en(rd_en), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .wb_empty(wb_empty)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [32:0] exp_probe(logic en, logic [15:0] a);
        logic [32:0] r = '0;
        if (en) for (int i = 0; i < qa.size(); i++) if (qa[i] == a) r = {1'b1, qd[i]};
        return r;
    endfunction

    // drive at negedge, check settled outputs, update model for the coming edge
    task automatic step(logic wv, logic [15:0] wa, logic [31:0] wd,
                        logic re, logic [15:0] ra, logic ack);
        logic [32:0] pr;
        logic pop, push;
        @(negedge clk);
        wr_valid = wv; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra; mem_ack = ack;
        #1;
        pr = exp_probe(re, ra);
        chk("R9 empty", wb_empty, qa.size() == 0);
        chk("R3 req", mem_req, qa.size() != 0);
        if (qa.size() != 0) begin
            chk("R3 oldest addr", mem_addr, qa[0]);
            chk("R3 oldest data", mem_data, qd[0]);
        end
        if (qa.size() < D) chk("R2 ready", wr_ready, 1'b1);
        else               chk("R5 ready when full", wr_ready, ack);
        chk("R6/R7/R8 hit", rd_hit, pr[32]);
        chk("R6/R7/R8 data", rd_data, pr[31:0]);
        pop  = ack && qa.size() != 0;
        push = wv && (qa.size() < D || pop);
        if (pop) begin void'(qa.pop_front()); void'(qd.pop_front()); end
        if (push) begin qa.push_back(wa); qd.push_back(wd); end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1 empty", wb_empty, 1'b1);
        chk("R1 req", mem_req, 1'b0);
        chk("R1 ready", wr_ready, 1'b1);
        chk("R1 hit", rd_hit, 1'b0);
        rst_n = 1'b1;
        step(0, 0, 0, 1, 16'h5, 0);
        // R2/R5/R7: fill with aliases, ack low
        step(1, 16'h5, 32'hA1, 0, 0, 0);
        step(1, 16'h6, 32'hB2, 1, 16'h5, 0);   // R6 visible next cycle
        step(1, 16'h5, 32'hC3, 1, 16'h5, 0);   // not yet the youngest
        step(1, 16'h7, 32'hD4, 1, 16'h5, 0);   // R7 youngest 5 -> C3
        step(1, 16'h8, 32'hE5, 1, 16'h9, 0);   // R5 full, refused; R8 miss
        step(1, 16'h8, 32'hE5, 1, 16'h8, 0);   // R5 still refused, R4 hold
        step(1, 16'h8, 32'hE6, 1, 16'h5, 1);   // R5 full + ack accepted, R10
        step(0, 0, 0, 1, 16'h8, 0);            // R6 new entry hit
        step(0, 0, 0, 0, 16'h8, 0);            // R8 rd_en low
        repeat (6) step(0, 0, 0, 1, 16'h7, 1); // drain to empty, R9
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] ph;
            ph = 3'((n / 300) % 8);
            step(($urandom % 3) != 0, 16'($urandom % 8), $urandom,
                 ($urandom % 4) != 0, 16'($urandom % 8),
                 (ph < 3) ? (($urandom % 6) == 0) : (($urandom % 2) == 0));
        end
        repeat (8) step(0, 0, 0, 1, 16'h1, 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end
endmodule